// File: doc/BRIEF.md
# Multi-Level Radix Table Walker

This block turns an effective address into a real address by walking a radix page table held in memory. A caller supplies the root table base, the root table's entry-count exponent, the total number of address bits the tree translates and the effective address, then pulses `start`. The walker reads one 64-bit entry per level over a simple request/response memory port. It follows directory entries until it reaches a leaf, and it reports the outcome with a single-cycle `done` pulse.

Each directory entry names the base and the entry-count exponent of the table below it. The index width can therefore change from level to level, and the page size is whatever remains of the translated-size exponent when a leaf is found. A walk ends with one of three outcomes: a real address, a configuration fault, or a missing-entry fault. The address of the last entry fetched stays on `leaf_addr` while the walker is idle, so that a later reference/change update can write to it. Permission checks and interrupt generation belong to other blocks.

Entry format: bit 63 is the valid flag, bit 62 the leaf flag, bits [PA_W-1:8] the next table base (its low 8 bits are zero), bits [4:0] the next entry-count exponent, and bits [PA_W-1:12] the real page number of a leaf.

Top module: `rtw_walker`

## Requirements
- R1: During and directly after reset, `done`, `flt_cfg`, `flt_miss` and `mem_req_valid` are low.
- R2: A level whose entry-count exponent is below 5 ends the walk with `flt_cfg` set, and no read is issued for that level. A root exponent below 5 gives a walk with zero reads.
- R3: The entry address read at each level is the level base plus 8 times the index. The index is the effective address shifted right by (remaining size minus the level's exponent), reduced modulo 2 to the power of that exponent. The low 3 bits of `root_base` are treated as zero.
- R4: A fetched entry with bit 63 clear ends the walk with `flt_miss` set.
- R5: A valid entry with bit 62 set ends the walk successfully. `page_shift` equals the total size minus the sum of the exponents of all levels read. Bits of `real_addr` below `page_shift` come from the effective address. Bits at or above it come from the entry, and an entry bit below 12 counts as zero.
- R6: A valid entry with bit 62 clear supplies the next level's base from bits [PA_W-1:8], with 8 zero bits appended, and the next level's exponent from bits [4:0].
- R7: A read request stays asserted with a stable address until `mem_req_ready` is high. Only one read is outstanding at a time, and exactly one read is issued per level visited.
- R8: A walk that has already issued MAX_LEVELS reads and needs another level ends with `flt_cfg` set.
- R9: A level whose entry-count exponent exceeds the remaining size exponent ends the walk with `flt_cfg` set.
- R10: After a walk, `leaf_addr` holds the address of the last entry fetched and stays unchanged until the next accepted `start`.
- R11: `done` is high for exactly one cycle per walk, and at most one of `flt_cfg` and `flt_miss` is set.
- R12: A `mem_rsp_valid` strobe that arrives while no read is awaiting its response has no effect on the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (accepted when idle) |
| root_base | input | PA_W | Root table base address |
| root_nls | input | 5 | Root table entry-count exponent |
| tot_size | input | SZ_W | Total translated-size exponent |
| ea | input | EA_W | Effective address to translate |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | PA_W | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 64 | Entry read from memory |
| done | output | 1 | Walk finished (one-cycle pulse) |
| flt_cfg | output | 1 | Bad-configuration fault |
| flt_miss | output | 1 | Missing-entry fault |
| real_addr | output | PA_W | Translated real address (valid without fault) |
| leaf_entry | output | 64 | Last entry fetched |
| leaf_addr | output | PA_W | Address of the last entry fetched |
| page_shift | output | SZ_W | Page-size exponent of the leaf |

## Verification
The assertions check, on every cycle, the handshake rules that hold regardless of table contents. These are: a stalled request keeps its address, request addresses are 8-byte aligned, `done` is a single-cycle pulse, at most one fault flag is set, and `leaf_addr` is held while idle. Only the bench scenarios can show that the walk lands on the right entry. They sweep effective addresses across tables that mix directories of different widths, leaves at several depths, invalid entries, too-small and too-large exponents and a self-referencing table. A bench-side model of the walk gives the expected real address, page shift, entry, entry address, fault and read count for every sweep point. Stray response strobes injected between reads show that they are ignored.

// File: rtl/rtw_pkg.sv
package rtw_pkg;
   localparam int ENT_W        = 64;
   localparam int VALID_BIT    = 63;
   localparam int LEAF_BIT     = 62;
   localparam int NLS_W        = 5;
   localparam int MIN_NLS      = 5;
   localparam int BASE_LO      = 8;
   localparam int RPN_LO       = 12;
   localparam int ADDR_HI_MAX  = 56;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_CALC,
      ST_REQ,
      ST_WAIT
   } walk_st_e;
endpackage

// File: rtl/rtw_index.sv
module rtw_index import rtw_pkg::*; #(
   parameter int PA_W = 56,
   parameter int EA_W = 64,
   parameter int SZ_W = 7
) (
   input  logic [EA_W-1:0]  ea,
   input  logic [PA_W-1:0]  base,
   input  logic [NLS_W-1:0] nls,
   input  logic [SZ_W-1:0]  rem,
   output logic [PA_W-1:0]  entry_addr,
   output logic             cfg_bad
);
   logic [7:0]  sh;
   logic [63:0] ea64;
   logic [63:0] mask64;
   logic [63:0] idx64;

   always_comb begin
      ea64   = 64'(ea);
      sh     = 8'(rem) - 8'(nls);
      mask64 = (64'd1 << nls) - 64'd1;
      idx64  = (ea64 >> sh) & mask64;
   end

   assign entry_addr = base + PA_W'(idx64 << 3);
   assign cfg_bad    = (nls < NLS_W'(MIN_NLS)) || (8'(nls) > 8'(rem));
endmodule

// File: rtl/rtw_compose.sv
module rtw_compose import rtw_pkg::*; #(
   parameter int PA_W = 56,
   parameter int SZ_W = 7
) (
   input  logic [PA_W-1:RPN_LO] pfn,
   input  logic [PA_W-1:0]      ea_lo,
   input  logic [SZ_W-1:0]      shift,
   output logic [PA_W-1:0]      ra
);
   for (genvar b = 0; b < PA_W; b++) begin : g_bit
      if (b < RPN_LO) begin : g_lo
         assign ra[b] = (SZ_W'(b) < shift) ? ea_lo[b] : 1'b0;
      end else begin : g_hi
         assign ra[b] = (SZ_W'(b) < shift) ? ea_lo[b] : pfn[b];
      end
   end
endmodule

// File: rtl/rtw_walker.sv
module rtw_walker import rtw_pkg::*; #(
   parameter int PA_W       = 56,
   parameter int EA_W       = 64,
   parameter int MAX_LEVELS = 8,
   localparam int SZ_W      = $clog2(EA_W + 1),
   localparam int LVL_W     = $clog2(MAX_LEVELS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [PA_W-1:0]  root_base,
   input  logic [NLS_W-1:0] root_nls,
   input  logic [SZ_W-1:0]  tot_size,
   input  logic [EA_W-1:0]  ea,
   output logic             mem_req_valid,
   input  logic             mem_req_ready,
   output logic [PA_W-1:0]  mem_req_addr,
   input  logic             mem_rsp_valid,
   input  logic [ENT_W-1:0] mem_rsp_data,
   output logic             done,
   output logic             flt_cfg,
   output logic             flt_miss,
   output logic [PA_W-1:0]  real_addr,
   output logic [ENT_W-1:0] leaf_entry,
   output logic [PA_W-1:0]  leaf_addr,
   output logic [SZ_W-1:0]  page_shift
);
   if (PA_W < 16 || PA_W > ADDR_HI_MAX) begin : g_bad_pa
      $error("rtw_walker: PA_W out of range");
   end
   if (EA_W < PA_W || EA_W > 64) begin : g_bad_ea
      $error("rtw_walker: EA_W must lie between PA_W and 64");
   end
   if (MAX_LEVELS < 1) begin : g_bad_lvl
      $error("rtw_walker: MAX_LEVELS must be at least 1");
   end

   walk_st_e         st_q;
   logic [EA_W-1:0]  ea_q;
   logic [PA_W-1:0]  base_q;
   logic [NLS_W-1:0] nls_q;
   logic [SZ_W-1:0]  rem_q;
   logic [LVL_W-1:0] lvl_q;
   logic [PA_W-1:0]  addr_q;
   logic             done_q, cfg_q, miss_q;
   logic [PA_W-1:0]  ra_q;
   logic [ENT_W-1:0] ent_q;
   logic [SZ_W-1:0]  ps_q;

   logic [PA_W-1:0]  idx_addr;
   logic             cfg_bad;
   logic [SZ_W-1:0]  rem_nx;
   logic [PA_W-1:0]  ra_nx;
   logic [PA_W-1:0]  nxt_base;

   rtw_index #(.PA_W(PA_W), .EA_W(EA_W), .SZ_W(SZ_W)) u_index (
      .ea         (ea_q),
      .base       (base_q),
      .nls        (nls_q),
      .rem        (rem_q),
      .entry_addr (idx_addr),
      .cfg_bad    (cfg_bad)
   );

   assign rem_nx   = rem_q - SZ_W'(nls_q);
   assign nxt_base = {mem_rsp_data[PA_W-1:BASE_LO], {BASE_LO{1'b0}}};

   rtw_compose #(.PA_W(PA_W), .SZ_W(SZ_W)) u_compose (
      .pfn   (mem_rsp_data[PA_W-1:RPN_LO]),
      .ea_lo (ea_q[PA_W-1:0]),
      .shift (rem_nx),
      .ra    (ra_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         ea_q   <= '0;
         base_q <= '0;
         nls_q  <= '0;
         rem_q  <= '0;
         lvl_q  <= '0;
         addr_q <= '0;
         done_q <= 1'b0;
         cfg_q  <= 1'b0;
         miss_q <= 1'b0;
         ra_q   <= '0;
         ent_q  <= '0;
         ps_q   <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  ea_q   <= ea;
                  base_q <= root_base & ~PA_W'(7);
                  nls_q  <= root_nls;
                  rem_q  <= tot_size;
                  lvl_q  <= '0;
                  cfg_q  <= 1'b0;
                  miss_q <= 1'b0;
                  st_q   <= ST_CALC;
               end
            end
            ST_CALC: begin
               if (cfg_bad || lvl_q == LVL_W'(MAX_LEVELS)) begin
                  cfg_q  <= 1'b1;
                  done_q <= 1'b1;
                  st_q   <= ST_IDLE;
               end else begin
                  addr_q <= idx_addr;
                  st_q   <= ST_REQ;
               end
            end
            ST_REQ: begin
               if (mem_req_ready) begin
                  lvl_q <= lvl_q + LVL_W'(1);
                  st_q  <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (mem_rsp_valid) begin
                  ent_q <= mem_rsp_data;
                  if (!mem_rsp_data[VALID_BIT]) begin
                     miss_q <= 1'b1;
                     done_q <= 1'b1;
                     st_q   <= ST_IDLE;
                  end else begin
                     rem_q <= rem_nx;
                     if (mem_rsp_data[LEAF_BIT]) begin
                        ra_q   <= ra_nx;
                        ps_q   <= rem_nx;
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                     end else begin
                        base_q <= nxt_base;
                        nls_q  <= mem_rsp_data[NLS_W-1:0];
                        st_q   <= ST_CALC;
                     end
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req_valid = (st_q == ST_REQ);
   assign mem_req_addr  = addr_q;
   assign done          = done_q;
   assign flt_cfg       = cfg_q;
   assign flt_miss      = miss_q;
   assign real_addr     = ra_q;
   assign leaf_entry    = ent_q;
   assign leaf_addr     = addr_q;
   assign page_shift    = ps_q;
endmodule

// File: rtl/rtw_walker_chk.sv
module rtw_walker_chk #(
   parameter int PA_W = 56
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic            idle,
   input logic            mem_req_valid,
   input logic            mem_req_ready,
   input logic [PA_W-1:0] mem_req_addr,
   input logic            done,
   input logic            flt_cfg,
   input logic            flt_miss,
   input logic [PA_W-1:0] leaf_addr
);
   // R7: a stalled request keeps its address
   a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

   // R3: entry addresses are 8-byte aligned
   a_r3_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> mem_req_addr[2:0] == 3'b000);

   // R11: completion is a single-cycle pulse
   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11: the two fault flags never appear together
   a_r11_fault_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({flt_cfg, flt_miss}));

   // R10: entry address held while idle and no new walk begins
   a_r10_leaf_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      idle && !start |=> $stable(leaf_addr));
endmodule

bind rtw_walker rtw_walker_chk #(.PA_W(PA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start         (start),
   .idle          (st_q == rtw_pkg::ST_IDLE),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .done          (done),
   .flt_cfg       (flt_cfg),
   .flt_miss      (flt_miss),
   .leaf_addr     (leaf_addr)
);

// File: tb/rtw_walker_bench.sv
module rtw_walker_bench;
   localparam int PA_W = 24;
   localparam int EA_W = 32;
   localparam int MAXL = 4;
   localparam int SZ_W = $clog2(EA_W + 1);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [PA_W-1:0] root_base = '0;
   logic [4:0]      root_nls = '0;
   logic [SZ_W-1:0] tot_size = '0;
   logic [EA_W-1:0] ea = '0;
   logic            mem_req_valid;
   logic            mem_req_ready = 1'b0;
   logic [PA_W-1:0] mem_req_addr;
   logic            mem_rsp_valid = 1'b0;
   logic [63:0]     mem_rsp_data = '0;
   logic            done, flt_cfg, flt_miss;
   logic [PA_W-1:0] real_addr, leaf_addr;
   logic [63:0]     leaf_entry;
   logic [SZ_W-1:0] page_shift;

   int total = 0;
   int bad = 0;
   logic [63:0] mem [0:1023];

   always #5 clk = ~clk;

   rtw_walker #(.PA_W(PA_W), .EA_W(EA_W), .MAX_LEVELS(MAXL)) u_rtw_walker (
      .clk(clk), .rst_n(rst_n), .start(start), .root_base(root_base),
      .root_nls(root_nls), .tot_size(tot_size), .ea(ea),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .done(done), .flt_cfg(flt_cfg),
      .flt_miss(flt_miss), .real_addr(real_addr), .leaf_entry(leaf_entry),
      .leaf_addr(leaf_addr), .page_shift(page_shift)
   );

   function automatic logic [63:0] rd(input logic [PA_W-1:0] a);
      if (a >= PA_W'(24'h2000)) return 64'd0;
      return mem[a[12:3]];
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // memory responder; stray strobes (R12) while nothing is awaited
   int tick = 0;
   bit pend = 1'b0;
   int dly = 0;
   int nreq = 0;
   logic [PA_W-1:0] paddr = '0;
   always @(negedge clk) begin
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      mem_req_ready = 1'b0;
      if (rst_n) begin
         tick++;
         if (pend) begin
            if (dly == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = rd(paddr);
               pend = 1'b0;
            end else dly--;
         end else if (mem_req_valid) begin
            if (tick % 3 != 0) begin
               mem_req_ready = 1'b1;
               pend  = 1'b1;
               paddr = mem_req_addr;
               dly   = tick % 2;
               nreq++;
            end
         end else if (tick % 4 == 1) begin
            mem_rsp_valid = 1'b1;
         end
      end
   end

   typedef struct {
      bit cfg; bit miss; logic [PA_W-1:0] ra; logic [PA_W-1:0] la;
      logic [63:0] ent; int ps; int nreq; int lv; int why;
   } exp_t;

   function automatic exp_t model(input logic [EA_W-1:0] e, input logic [PA_W-1:0] b0,
                                  input int n0, input int tot);
      exp_t r;
      int rem = tot;
      int n = n0;
      logic [63:0] b = 64'(b0) & ~64'd7;
      logic [63:0] idx, a, ent;
      r = '{default: 0};
      while (1) begin
         if (n < 5) begin r.cfg = 1; r.why = 2; break; end
         if (n > rem) begin r.cfg = 1; r.why = 9; break; end
         if (r.lv == MAXL) begin r.cfg = 1; r.why = 8; break; end
         idx = (64'(e) >> (rem - n)) & ((64'd1 << n) - 64'd1);
         a = b + idx * 64'd8;
         ent = rd(PA_W'(a));
         r.nreq++;
         r.la = PA_W'(a);
         r.ent = ent;
         if (!ent[63]) begin r.miss = 1; break; end
         rem -= n;
         r.lv++;
         if (ent[62]) begin
            for (int i = 0; i < PA_W; i++)
               r.ra[i] = (i < rem) ? e[i] : ((i >= 12) ? ent[i] : 1'b0);
            r.ps = rem;
            break;
         end
         b = 64'(ent[PA_W-1:8]) << 8;
         n = int'(ent[4:0]);
      end
      return r;
   endfunction

   function automatic logic [63:0] mk_leaf(input logic [11:0] v);
      return 64'hC000_0A00_0000_00A5 | (64'(v) << 12);
   endfunction

   function automatic logic [63:0] mk_dir(input logic [PA_W-1:0] b, input int n);
      return 64'h8000_0000_0000_0000 | 64'(b) | 64'(n);
   endfunction

   localparam logic [63:0] JUNK_INV = 64'h4000_0000_0012_3000;

   task automatic walk(input logic [EA_W-1:0] e, input logic [PA_W-1:0] b,
                       input int n, input int tot);
      exp_t x;
      string ctag;
      logic [PA_W-1:0] snap;
      x = model(e, b, n, tot);
      ctag = (x.why == 2) ? "R2 config fault" : (x.why == 9) ? "R9 config fault" :
             (x.why == 8) ? "R8 config fault" : "R2 R8 R9 no config fault";
      @(negedge clk);
      ea = e; root_base = b; root_nls = 5'(n); tot_size = SZ_W'(tot);
      nreq = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      chk(ctag, 64'(flt_cfg), 64'(x.cfg));
      chk("R4 missing-entry fault", 64'(flt_miss), 64'(x.miss));
      chk("R7 read count", 64'(nreq), 64'(x.nreq));
      chk("R11 single fault", 64'(flt_cfg & flt_miss), 64'd0);
      if (!x.cfg && !x.miss) begin
         chk("R5 R12 real address", 64'(real_addr), 64'(x.ra));
         chk("R5 page shift", 64'(page_shift), 64'(x.ps));
         chk("R3 leaf entry address", 64'(leaf_addr), 64'(x.la));
         chk(x.lv > 1 ? "R6 leaf entry via directory" : "R5 leaf entry", leaf_entry, x.ent);
      end
      snap = leaf_addr;
      @(negedge clk);
      chk("R11 done pulse", 64'(done), 64'd0);
      repeat (2) @(negedge clk);
      chk("R10 entry address held", 64'(leaf_addr), 64'(snap));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL R11 watchdog: done=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int w = 0; w < 1024; w++) mem[w] = 64'd0;
      // root table at 0x000, 32 entries
      for (int i = 0; i < 32; i++) begin
         case (i % 8)
            0, 4:    mem[i] = mk_dir(PA_W'(24'h100), 6);
            1, 5:    mem[i] = mk_leaf(12'(12'h900 + i * 37));
            2:       mem[i] = JUNK_INV;
            3:       mem[i] = mk_dir(PA_W'(24'h400), 4);
            6:       mem[i] = mk_dir(PA_W'(24'h400), 5);
            default: mem[i] = mk_dir(PA_W'(24'h400), 20);
         endcase
      end
      // second table at 0x100, 64 entries
      for (int j = 0; j < 64; j++) begin
         case (j % 3)
            0:       mem[32 + j] = JUNK_INV;
            1:       mem[32 + j] = mk_leaf(12'(12'h500 + j * 11));
            default: mem[32 + j] = mk_dir(PA_W'(24'h400), 5);
         endcase
      end
      // third table at 0x400, 32 entries
      for (int k = 0; k < 32; k++)
         mem[128 + k] = (k % 2 == 0) ? mk_leaf(12'(12'h300 + k * 5)) : JUNK_INV;
      // self-referencing table at 0x800
      for (int k = 0; k < 32; k++) mem[256 + k] = mk_dir(PA_W'(24'h800), 5);

      repeat (3) @(negedge clk);
      chk("R1 done after reset", 64'(done), 64'd0);
      chk("R1 flt_cfg after reset", 64'(flt_cfg), 64'd0);
      chk("R1 flt_miss after reset", 64'(flt_miss), 64'd0);
      chk("R1 request after reset", 64'(mem_req_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 request idle", 64'(mem_req_valid), 64'd0);

      for (int i = 0; i < 32; i++) begin
         for (int s = 0; s < 4; s++) begin
            logic [EA_W-1:0] e;
            int j, k, lo;
            j  = (i * 5 + s * 17) % 64;
            k  = (i + s * 3) % 32;
            lo = (i * 131 + s * 977) % 256;
            e  = {8'(8'hA5 ^ 8'(s)), 5'(i), 6'(j), 5'(k), 8'(lo)};
            walk(e, '0, 5, 24);
         end
      end
      for (int i = 0; i < 32; i++)
         walk(EA_W'(32'h0123_4567 ^ (i << 27) ^ (i << 9)), '0, 5, 32);
      walk(EA_W'(32'h00F0_0000), '0, 4, 24);                // R2 at the root
      walk(EA_W'(32'h00F0_0000), '0, 0, 24);                // R2 zero exponent
      walk(EA_W'(32'h00F0_0000), '0, 25, 24);               // R9 at the root
      walk(EA_W'(32'h1234_5678), PA_W'(24'h800), 5, 30);    // R8 bound
      walk(EA_W'(32'h1234_5678), PA_W'(24'h800), 5, 20);    // runs out of size
      walk(EA_W'(32'h0028_6A3C), PA_W'(24'h000003), 5, 24); // R3 base alignment
      walk(EA_W'(32'h00A8_6A3C), PA_W'(24'h000005), 5, 24);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule